// File: doc/BRIEF.md
# Frequency-Change Watchdog with Safe-Setting Recovery

This block guards the output-frequency selection of a programmable clock generator. When software asks for a new frequency code and the watchdog is armed, a countdown starts. Software confirms that the system survived the new setting by clearing the enable bit, which stops the countdown. If the countdown runs out first, the block raises a sticky expiry flag. It replaces the selection with a safe code that is held since power-up, and it refuses every further frequency request until software clears the enable bit. Two independent enables let the block drive a fixed-length system reset pulse, one on expiry and one on every frequency request.

Software uses a small four-word register port. The clock-generator side sees a request strobe with a code, the selected code, and the reset pulse. The timeout is (k+1) units, where k is a 5-bit field. A unit is one of two parameterised cycle counts, chosen by a prescaler bit.

Top module: `clkgen_watchdog`

## Requirements
- R1: Setting the enable bit (address 0, bit 0) starts no countdown. The countdown starts only when a frequency request is accepted while that bit is 1. A request accepted while the bit is 0 never leads to expiry.
- R2: Expiry happens exactly (k+1)·U clock edges after the edge that accepts the request. k is address 1, bits [4:0]. U is SHORT_UNIT_CYC when address 0 bit 1 is 0, and LONG_UNIT_CYC when it is 1.
- R3: Any write to address 0 with bit 0 equal to 0 stops a running countdown, so no expiry follows.
- R4: Address 2 bit 0 is set on expiry and stays set. Writing 1 to it clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves it set.
- R5: On the expiry edge the selected code becomes SAFE_FREQ and the block locks. Address 2 bit 1 reads 1 while locked.
- R6: While the block is locked, frequency requests change nothing. A write to address 0 with bit 0 equal to 0 unlocks it, and requests are accepted again.
- R7: With address 0 bit 2 set, expiry produces a reset pulse of RST_CYC cycles that starts at the expiry edge. With the bit clear, expiry produces no pulse.
- R8: With address 0 bit 3 set, each request made while unlocked produces a reset pulse of RST_CYC cycles that starts at the accepting edge.
- R9: Both reset sources firing on the same edge give a single pulse of RST_CYC cycles. A new trigger during a pulse restarts its length.
- R10: A request accepted while the countdown is running restarts it from the programmed value.
- R11: After reset the selected code is SAFE_FREQ, the pulse output is low, and addresses 0, 1 and 2 read 0. A read returns the word at the address sampled on the previous edge. Address 3 returns the selected code.
- R12: An accepted request sets the selected code on its accepting edge. If that edge is also the expiry edge, the safe code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| chg_valid | input | 1 | Frequency change request strobe |
| chg_code | input | FREQ_W | Requested frequency code |
| freq_sel | output | FREQ_W | Selected frequency code |
| sys_rst_pulse | output | 1 | System reset pulse |

## Verification
The selected code changes on the accepting edge, so it is checked at the falling edge that follows. Expiry is due (k+1)·U edges later, and the bench checks the held code at every falling edge before that point and the safe code at exactly that one. The reset pulse is checked high for each of its RST_CYC falling edges and low at the one after them. Register reads take one edge, so the bench presents the address and samples data at the next falling edge. Collisions are driven so that the request or the clearing write lands on the computed expiry edge.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;

  localparam int REG_ADDR_W = 2;
  localparam int REG_DATA_W = 8;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_TMO  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_FREQ = 2'd3
  } reg_addr_e;

  // control word, bit 0 is the enable
  typedef struct packed {
    logic rst_on_chg;   // bit 3
    logic rst_on_exp;   // bit 2
    logic long_unit;    // bit 1
    logic wd_on;        // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/clkwd_regs.sv
module clkwd_regs
  import clkwd_pkg::*;
#(
  parameter int TMO_W  = 5,
  parameter int FREQ_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [REG_DATA_W-1:0] wdata_i,
  input  logic                  expire_i,
  input  logic [FREQ_W-1:0]     freq_i,
  output ctrl_t                 ctrl_o,
  output logic [TMO_W-1:0]      tmo_o,
  output logic                  locked_o,
  output logic                  stop_o,
  output logic [REG_DATA_W-1:0] rdata_o
);

  logic ctrl_wr, stat_wr, tmo_wr;
  logic expired_q;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign tmo_wr  = we_i && (addr_i == ADDR_TMO);
  assign stat_wr = we_i && (addr_i == ADDR_STAT);
  assign stop_o  = ctrl_wr && !wdata_i[0];

  wire unused_wdata = ^wdata_i[REG_DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      tmo_o  <= '0;
    end else begin
      if (ctrl_wr) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (tmo_wr)  tmo_o  <= wdata_i[TMO_W-1:0];
    end
  end

  // sticky flag: setting beats a clearing write
  always_ff @(posedge clk) begin
    if (rst)                        expired_q <= 1'b0;
    else if (expire_i)              expired_q <= 1'b1;
    else if (stat_wr && wdata_i[0]) expired_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           locked_o <= 1'b0;
    else if (expire_i) locked_o <= 1'b1;
    else if (stop_o)   locked_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      unique case (reg_addr_e'(addr_i))
        ADDR_CTRL: rdata_o <= REG_DATA_W'(ctrl_o);
        ADDR_TMO:  rdata_o <= REG_DATA_W'(tmo_o);
        ADDR_STAT: rdata_o <= REG_DATA_W'({locked_o, expired_q});
        ADDR_FREQ: rdata_o <= REG_DATA_W'(freq_i);
        default:   rdata_o <= '0;
      endcase
    end
  end

  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> expired_q); // R4
  AST_W0_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (expired_q && stat_wr && !wdata_i[0]) |=> expired_q); // R4
  AST_LOCK_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> locked_o); // R5

endmodule

// File: rtl/clkwd_timer.sv
module clkwd_timer #(
  parameter int TMO_W          = 5,
  parameter int SHORT_UNIT_CYC = 30_000_000,
  parameter int LONG_UNIT_CYC  = 500_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             long_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             expire_o
);

  localparam int MAX_UNIT = (LONG_UNIT_CYC > SHORT_UNIT_CYC) ? LONG_UNIT_CYC : SHORT_UNIT_CYC;
  localparam int PRE_W    = (MAX_UNIT > 1) ? $clog2(MAX_UNIT) : 1;
  localparam logic [PRE_W-1:0] SHORT_RELOAD = PRE_W'(SHORT_UNIT_CYC - 1);
  localparam logic [PRE_W-1:0] LONG_RELOAD  = PRE_W'(LONG_UNIT_CYC - 1);

  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] units_q;
  logic             run_q, long_q, at_end;

  assign at_end   = run_q && (pre_q == '0) && (units_q == '0);
  assign expire_o = at_end && !stop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      long_q  <= 1'b0;
      pre_q   <= '0;
      units_q <= '0;
    end else if (stop_i || at_end) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      long_q  <= long_i;
      units_q <= tmo_i;
      pre_q   <= long_i ? LONG_RELOAD : SHORT_RELOAD;
    end else if (run_q) begin
      if (pre_q == '0) begin
        units_q <= units_q - 1'b1;
        pre_q   <= long_q ? LONG_RELOAD : SHORT_RELOAD;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> !run_q); // R1
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!run_q && !expire_o)); // R3

endmodule

// File: rtl/clkwd_pulse.sv
module clkwd_pulse #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_a_i,
  input  logic trig_b_i,
  output logic pulse_o
);

  logic trig;
  assign trig = trig_a_i || trig_b_i;

  generate
    if (PULSE_CYC <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b0;
        else     pulse_o <= trig;
      end
    end else begin : g_count
      localparam int CNT_W = $clog2(PULSE_CYC);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pulse_o <= 1'b0;
          cnt_q   <= '0;
        end else if (trig) begin
          pulse_o <= 1'b1;
          cnt_q   <= CNT_W'(PULSE_CYC - 1);
        end else if (pulse_o) begin
          if (cnt_q == '0) pulse_o <= 1'b0;
          else             cnt_q   <= cnt_q - 1'b1;
        end
      end
    end
  endgenerate

  AST_TRIGGER_PULSES: assert property (@(posedge clk) disable iff (rst)
    trig |=> pulse_o); // R9

endmodule

// File: rtl/clkgen_watchdog.sv
module clkgen_watchdog
  import clkwd_pkg::*;
#(
  parameter int              FREQ_W         = 5,
  parameter int              TMO_W          = 5,
  parameter int              SHORT_UNIT_CYC = 30_000_000,
  parameter int              LONG_UNIT_CYC  = 500_000_000,
  parameter int              RST_CYC        = 16,
  parameter logic [FREQ_W-1:0] SAFE_FREQ    = 5'd2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  input  logic                  chg_valid,
  input  logic [FREQ_W-1:0]     chg_code,
  output logic [FREQ_W-1:0]     freq_sel,
  output logic                  sys_rst_pulse
);

  ctrl_t             ctrl;
  logic [TMO_W-1:0]  tmo;
  logic              locked, expire, stop, accept;
  logic [FREQ_W-1:0] safe_q;

  assign accept = chg_valid && !locked;

  clkwd_regs #(.TMO_W(TMO_W), .FREQ_W(FREQ_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .expire_i(expire), .freq_i(freq_sel), .ctrl_o(ctrl), .tmo_o(tmo),
    .locked_o(locked), .stop_o(stop), .rdata_o(reg_rdata)
  );

  clkwd_timer #(
    .TMO_W(TMO_W), .SHORT_UNIT_CYC(SHORT_UNIT_CYC), .LONG_UNIT_CYC(LONG_UNIT_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .start_i(accept && ctrl.wd_on), .stop_i(stop),
    .long_i(ctrl.long_unit), .tmo_i(tmo), .expire_o(expire)
  );

  clkwd_pulse #(.PULSE_CYC(RST_CYC)) u_pulse (
    .clk(clk), .rst(rst),
    .trig_a_i(expire && ctrl.rst_on_exp),
    .trig_b_i(accept && ctrl.rst_on_chg),
    .pulse_o(sys_rst_pulse)
  );

  // safe code captured at power-up and never rewritten
  always_ff @(posedge clk) begin
    if (rst) safe_q <= SAFE_FREQ;
  end

  always_ff @(posedge clk) begin
    if (rst)         freq_sel <= SAFE_FREQ;
    else if (expire) freq_sel <= safe_q;
    else if (accept) freq_sel <= chg_code;
  end

  AST_SAFE_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    expire |=> (freq_sel == SAFE_FREQ)); // R5
  AST_LOCKED_FREQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (locked && !stop) |=> $stable(freq_sel)); // R6

endmodule

// File: tb/clkgen_watchdog_test.sv
`timescale 1ns/1ps
module clkgen_watchdog_test;

  localparam int FW = 5;
  localparam int SU = 3;
  localparam int LU = 5;
  localparam int RC = 4;
  localparam logic [FW-1:0] SAFE = 5'h15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic chg_valid = 1'b0;
  logic [FW-1:0] chg_code = '0;
  logic [FW-1:0] freq_sel;
  logic sys_rst_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  clkgen_watchdog #(
    .FREQ_W(FW), .TMO_W(5), .SHORT_UNIT_CYC(SU), .LONG_UNIT_CYC(LU),
    .RST_CYC(RC), .SAFE_FREQ(SAFE)
  ) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chg_valid(chg_valid), .chg_code(chg_code),
    .freq_sel(freq_sel), .sys_rst_pulse(sys_rst_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic chg(input logic [FW-1:0] c);
    chg_valid = 1'b1; chg_code = c;
    @(negedge clk);
    chg_valid = 1'b0;
  endtask

  // entered at the falling edge just after the accepting edge
  task automatic expect_expiry(input logic [FW-1:0] c, input int t, input bit pulse_exp,
                               input string req);
    for (int i = 0; i < t; i++) begin
      chk(freq_sel == c, req, freq_sel, c);
      chk(sys_rst_pulse == 1'b0, "R7 no pulse before expiry", sys_rst_pulse, 0);
      @(negedge clk);
    end
    chk(freq_sel == SAFE, "R5 safe code at expiry edge", freq_sel, SAFE);
    for (int j = 0; j < RC; j++) begin
      chk(sys_rst_pulse == pulse_exp, "R7 expiry pulse", sys_rst_pulse, pulse_exp);
      @(negedge clk);
    end
    chk(sys_rst_pulse == 1'b0, "R7 pulse ended", sys_rst_pulse, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, run hung");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk(freq_sel == SAFE, "R11 reset code", freq_sel, SAFE);
    chk(sys_rst_pulse == 1'b0, "R11 reset pulse low", sys_rst_pulse, 0);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      chk(d == 8'h00, "R11 reset register", d, 0);
    end
    rd(2'd3, d);
    chk(d == 8'(SAFE), "R11 code readback", d, SAFE);

    // R1: enabling alone starts nothing
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h05);
    repeat (60) @(negedge clk);
    rd(2'd2, d);
    chk(d == 8'h00, "R1 enable alone no expiry", d, 0);
    chk(freq_sel == SAFE, "R1 code untouched", freq_sel, SAFE);

    // R8 / R12 / R1: change while disabled, reset on change only
    wr(2'd0, 8'h08);
    chg(5'h07);
    chk(freq_sel == 5'h07, "R12 code on accepting edge", freq_sel, 7);
    for (int j = 0; j < RC; j++) begin
      chk(sys_rst_pulse == 1'b1, "R8 change pulse", sys_rst_pulse, 1);
      @(negedge clk);
    end
    chk(sys_rst_pulse == 1'b0, "R8 change pulse length", sys_rst_pulse, 0);
    repeat (40) @(negedge clk);
    rd(2'd2, d);
    chk(d == 8'h00, "R1 disabled change never expires", d, 0);

    // R9 retrigger during a pulse restarts the length
    chg(5'h09);
    chg_valid = 1'b1; chg_code = 5'h0A;
    @(negedge clk);
    chg_valid = 1'b0;
    for (int j = 0; j < RC; j++) begin
      chk(sys_rst_pulse == 1'b1, "R9 retriggered pulse", sys_rst_pulse, 1);
      @(negedge clk);
    end
    chk(sys_rst_pulse == 1'b0, "R9 retriggered pulse end", sys_rst_pulse, 0);
    wr(2'd0, 8'h00);

    // R2 R4 R5 R6 R7 R11 sweep of every timeout and both units
    for (int lg = 0; lg < 2; lg++) begin
      for (int k = 0; k < 32; k++) begin
        logic [FW-1:0] c;
        int t;
        c = (k % 2 == 1) ? 5'h07 : 5'h0B;
        t = (k + 1) * ((lg == 1) ? LU : SU);
        wr(2'd1, 8'(k));
        wr(2'd0, 8'(8'h05 | (lg << 1)));
        chg(c);
        expect_expiry(c, t, 1'b1, "R2 code held until timeout");
        rd(2'd2, d);
        chk(d == 8'h03, "R4 R5 flag and lock set", d, 3);
        chg(5'h01);
        chk(freq_sel == SAFE, "R6 locked ignores request", freq_sel, SAFE);
        wr(2'd2, 8'h00);
        rd(2'd2, d);
        chk(d == 8'h03, "R4 writing 0 keeps flag", d, 3);
        wr(2'd2, 8'h01);
        rd(2'd2, d);
        chk(d == 8'h02, "R4 writing 1 clears flag", d, 2);
        wr(2'd0, 8'h00);
        rd(2'd2, d);
        chk(d == 8'h00, "R6 unlock by clearing enable", d, 0);
        rd(2'd3, d);
        chk(d == 8'(SAFE), "R11 code readback after expiry", d, SAFE);
      end
    end

    // R6 unlocked requests accepted again
    chg(5'h09);
    chk(freq_sel == 5'h09, "R6 request accepted after unlock", freq_sel, 9);

    // R3 clearing enable mid-count stops it
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h05);
    chg(5'h0C);
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h04);
    repeat (40) @(negedge clk);
    chk(freq_sel == 5'h0C, "R3 stopped countdown keeps code", freq_sel, 12);
    chk(sys_rst_pulse == 1'b0, "R3 no expiry pulse", sys_rst_pulse, 0);
    rd(2'd2, d);
    chk(d == 8'h00, "R3 no expiry flag", d, 0);

    // R10 request while running restarts countdown
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h05);
    chg(5'h0D);
    repeat (5) @(negedge clk);
    chg(5'h0E);
    expect_expiry(5'h0E, 3 * SU, 1'b1, "R10 restarted countdown");
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);

    // R4 expiry beats a clearing write on the same edge (k=0, short: t=3)
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h01);
    chg(5'h06);
    repeat (2) @(negedge clk);
    wr(2'd2, 8'h01);
    chk(freq_sel == SAFE, "R5 expiry edge", freq_sel, SAFE);
    rd(2'd2, d);
    chk(d == 8'h03, "R4 set beats clear", d, 3);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);

    // R9 R12 both reset sources on one edge (k=0, long: t=5)
    wr(2'd0, 8'h0F);
    chg(5'h06);
    repeat (4) @(negedge clk);
    chk(sys_rst_pulse == 1'b0, "R9 first pulse over", sys_rst_pulse, 0);
    chg(5'h08);
    chk(freq_sel == SAFE, "R12 expiry wins over request", freq_sel, SAFE);
    for (int j = 0; j < RC; j++) begin
      chk(sys_rst_pulse == 1'b1, "R9 merged pulse", sys_rst_pulse, 1);
      @(negedge clk);
    end
    chk(sys_rst_pulse == 1'b0, "R9 single pulse length", sys_rst_pulse, 0);

    // R7 expiry without its reset enable gives no pulse
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h01);
    chg(5'h04);
    expect_expiry(5'h04, 2 * SU, 1'b0, "R7 code held, pulse disabled");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule